// File: doc/BRIEF.md
# Shared IN-Endpoint Transmit Completion Flag

This block holds the transmit-completion status for two IN endpoints of a USB device function that draw their data from one common transmit buffer. When the protocol engine reports that the host acknowledged a data packet sent from that buffer, a single completion flag is raised. Software reads the flag through an 8-bit status/control register. It clears the flag by writing a one to the flag's bit position, and it may enable an interrupt on the flag.

The same flag gates the replies to IN tokens. While the flag is set, any IN token on either shared endpoint is answered with NAK. Data is offered only when the flag has been cleared and the transmit-enable input is high. Tokens for other endpoints are left alone. The block drives no handshake decision for them, and they cannot touch the flag.

Top module: `txflag_ctrl_top`

## Requirements
- R1: After synchronous reset, `reg_rdata` reads 8'h00, `irq` is 0 and `hs_vld` is 0.
- R2: Register layout: bit 7 reads the completion flag. Bit 0 is a read/write interrupt enable, updated by every write. Bits 6..1 always read 0, whatever value was written to them.
- R3: The flag is set one cycle after `ack_vld` is seen for endpoint 1 or 2, but only if an earlier IN token received a DATA decision that is not yet acknowledged. An ACK with no DATA outstanding, or an ACK for another endpoint, leaves the flag unchanged.
- R4: Endpoints 1 and 2 share the flag. A DATA decision followed by an ACK on either endpoint sets it.
- R5: A write with bit 7 = 1 clears the flag at the next clock. A write with bit 7 = 0 leaves it unchanged. No write can set it.
- R6: The cycle after an IN token on endpoint 1 or 2, `hs_vld` is 1. If the flag was set when the token arrived, `hs_type` is NAK (2'd2).
- R7: The decision for a token on endpoint 1 or 2 is DATA (2'd1) only when the flag is clear and `tx_arm` is 1. Otherwise it is NAK (2'd2).
- R8: `irq` equals the AND of register bit 7 and register bit 0, in every cycle.
- R9: If a setting ACK and a clearing write occur in the same cycle, the flag ends up set.
- R10: The cycle after an IN token on any endpoint other than 1 or 2, `hs_vld` is 0 and `hs_type` is 2'd0. The flag is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| tx_arm | input | 1 | Transmit-enable control bit |
| tok_vld | input | 1 | IN token seen by the protocol engine |
| tok_ep | input | 4 | Endpoint number of the IN token |
| ack_vld | input | 1 | Host ACK received for a sent data packet |
| ack_ep | input | 4 | Endpoint number of the acknowledged packet |
| hs_vld | output | 1 | Handshake decision valid |
| hs_type | output | 2 | 0 none, 1 DATA, 2 NAK |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that each token and each ACK is a single-cycle pulse, and that an ACK always follows a DATA decision on the same endpoint. The bench drives every event for exactly one cycle and waits for the decision before the next event. The sweep covers all 16 endpoint numbers against every combination of flag state, transmit enable and interrupt enable. Directed cases cover stray ACKs, an ACK on another endpoint and a clearing write that coincides with an ACK.

// File: rtl/txflag_pkg.sv
package txflag_pkg;
  typedef enum logic [1:0] {
    HS_NONE = 2'd0,
    HS_DATA = 2'd1,
    HS_NAK  = 2'd2
  } hs_e;
endpackage

// File: rtl/txflag_regif.sv
module txflag_regif #(
  parameter int DATA_W   = 8,
  parameter int FLAG_BIT = 7,
  parameter int IE_BIT   = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              flag,
  output logic              clr_pulse,
  output logic              ie_nxt,
  output logic [DATA_W-1:0] rdata
);
  logic ie_q;

  assign clr_pulse = wr & wdata[FLAG_BIT];
  assign ie_nxt    = wr ? wdata[IE_BIT] : ie_q;

  always_ff @(posedge clk) begin
    if (rst) ie_q <= 1'b0;
    else     ie_q <= ie_nxt;
  end

  for (genvar b = 0; b < DATA_W; b++) begin : g_rd
    if (b == FLAG_BIT) begin : g_flag
      assign rdata[b] = flag;
    end else if (b == IE_BIT) begin : g_ie
      assign rdata[b] = ie_q;
    end else begin : g_pad
      assign rdata[b] = 1'b0;
    end
  end

  // R2
  ie_write_chk: assert property (@(posedge clk) disable iff (rst)
    wr |=> (rdata[IE_BIT] == $past(wdata[IE_BIT])));
endmodule

// File: rtl/txflag_core.sv
module txflag_core #(
  parameter int EP_W = 4,
  parameter int EP_A = 1,
  parameter int EP_B = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ack_vld,
  input  logic [EP_W-1:0] ack_ep,
  input  logic            data_sent,
  input  logic            clr_pulse,
  input  logic            ie_nxt,
  output logic            flag_q,
  output logic            irq
);
  logic pend_q, ack_shared, set_evt, flag_nxt;

  assign ack_shared = ack_vld && (ack_ep == EP_W'(EP_A) || ack_ep == EP_W'(EP_B));
  assign set_evt    = ack_shared & pend_q;
  assign flag_nxt   = set_evt ? 1'b1 : (clr_pulse ? 1'b0 : flag_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      pend_q <= 1'b0;
      irq    <= 1'b0;
    end else begin
      flag_q <= flag_nxt;
      irq    <= flag_nxt & ie_nxt;
      if (data_sent)    pend_q <= 1'b1;
      else if (set_evt) pend_q <= 1'b0;
    end
  end

  // R9
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_shared && pend_q && clr_pulse) |=> flag_q);
  // R5
  clear_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_pulse && !(ack_shared && pend_q)) |=> !flag_q);
  // R3
  no_stray_set_chk: assert property (@(posedge clk) disable iff (rst)
    (!flag_q && !ack_shared) |=> !flag_q);
endmodule

// File: rtl/txflag_hs.sv
module txflag_hs
  import txflag_pkg::*;
#(
  parameter int EP_W = 4,
  parameter int EP_A = 1,
  parameter int EP_B = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tok_vld,
  input  logic [EP_W-1:0] tok_ep,
  input  logic            flag,
  input  logic            tx_arm,
  output logic            data_sent,
  output logic            hs_vld,
  output logic [1:0]      hs_type
);
  logic tok_shared, give_data;
  hs_e  dec;

  assign tok_shared = tok_vld && (tok_ep == EP_W'(EP_A) || tok_ep == EP_W'(EP_B));
  assign give_data  = !flag && tx_arm;
  assign data_sent  = tok_shared & give_data;
  assign dec        = !tok_shared ? HS_NONE : (give_data ? HS_DATA : HS_NAK);

  always_ff @(posedge clk) begin
    if (rst) begin
      hs_vld  <= 1'b0;
      hs_type <= HS_NONE;
    end else begin
      hs_vld  <= tok_shared;
      hs_type <= dec;
    end
  end

  // R6
  nak_while_set_chk: assert property (@(posedge clk) disable iff (rst)
    (tok_shared && flag) |=> (hs_vld && hs_type == HS_NAK));
  // R7
  nak_unarmed_chk: assert property (@(posedge clk) disable iff (rst)
    (tok_shared && !tx_arm) |=> (hs_type == HS_NAK));
  // R10
  other_ep_chk: assert property (@(posedge clk) disable iff (rst)
    (!tok_shared) |=> (!hs_vld && hs_type == HS_NONE));
endmodule

// File: rtl/txflag_ctrl_top.sv
module txflag_ctrl_top #(
  parameter int DATA_W   = 8,
  parameter int EP_W     = 4,
  parameter int EP_A     = 1,
  parameter int EP_B     = 2,
  parameter int FLAG_BIT = 7,
  parameter int IE_BIT   = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              tx_arm,
  input  logic              tok_vld,
  input  logic [EP_W-1:0]   tok_ep,
  input  logic              ack_vld,
  input  logic [EP_W-1:0]   ack_ep,
  output logic              hs_vld,
  output logic [1:0]        hs_type,
  output logic              irq
);
  logic flag, clr_pulse, ie_nxt, data_sent;

  txflag_regif #(.DATA_W(DATA_W), .FLAG_BIT(FLAG_BIT), .IE_BIT(IE_BIT)) u_regif (
    .clk(clk), .rst(rst), .wr(reg_wr), .wdata(reg_wdata), .flag(flag),
    .clr_pulse(clr_pulse), .ie_nxt(ie_nxt), .rdata(reg_rdata)
  );

  txflag_core #(.EP_W(EP_W), .EP_A(EP_A), .EP_B(EP_B)) u_core (
    .clk(clk), .rst(rst), .ack_vld(ack_vld), .ack_ep(ack_ep),
    .data_sent(data_sent), .clr_pulse(clr_pulse), .ie_nxt(ie_nxt),
    .flag_q(flag), .irq(irq)
  );

  txflag_hs #(.EP_W(EP_W), .EP_A(EP_A), .EP_B(EP_B)) u_hs (
    .clk(clk), .rst(rst), .tok_vld(tok_vld), .tok_ep(tok_ep), .flag(flag),
    .tx_arm(tx_arm), .data_sent(data_sent), .hs_vld(hs_vld), .hs_type(hs_type)
  );

  // R8
  irq_match_chk: assert property (@(posedge clk) disable iff (rst)
    irq == (reg_rdata[FLAG_BIT] & reg_rdata[IE_BIT]));
endmodule

// File: tb/txflag_ctrl_top_tb.sv
module txflag_ctrl_top_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       tx_arm = 1'b0;
  logic       tok_vld = 1'b0;
  logic [3:0] tok_ep = 4'd0;
  logic       ack_vld = 1'b0;
  logic [3:0] ack_ep = 4'd0;
  logic       hs_vld;
  logic [1:0] hs_type;
  logic       irq;
  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  txflag_ctrl_top u_dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .tx_arm(tx_arm), .tok_vld(tok_vld), .tok_ep(tok_ep),
    .ack_vld(ack_vld), .ack_ep(ack_ep), .hs_vld(hs_vld), .hs_type(hs_type),
    .irq(irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    tick();
    tick();
    rst = 1'b0;
  endtask

  task automatic wr(input logic [7:0] d);
    reg_wr = 1'b1;
    reg_wdata = d;
    tick();
    reg_wr = 1'b0;
  endtask

  task automatic tok(input logic [3:0] ep);
    tok_vld = 1'b1;
    tok_ep = ep;
    tick();
    tok_vld = 1'b0;
  endtask

  task automatic ack(input logic [3:0] ep);
    ack_vld = 1'b1;
    ack_ep = ep;
    tick();
    ack_vld = 1'b0;
  endtask

  task automatic set_flag(input logic [3:0] ep, input logic ie);
    wr({1'b1, 6'b0, ie});
    tx_arm = 1'b1;
    tok(ep);
    ack(ep);
  endtask

  initial begin
    #2_000_000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R1 reset state
    chk("R1 rdata", reg_rdata, 8'h00);
    chk("R1 irq", irq, 0);
    chk("R1 hs_vld", hs_vld, 0);

    // R2 padding bits read zero, IE read/write
    wr(8'h7F);
    chk("R2 pad/ie", reg_rdata, 8'h01);
    wr(8'h7E);
    chk("R2 ie cleared", reg_rdata, 8'h00);

    // R3 ACK with no DATA outstanding is ignored
    ack(4'd1);
    chk("R3 stray ack", reg_rdata[7], 0);
    // R3 ACK for another endpoint is ignored
    tx_arm = 1'b1;
    tok(4'd1);
    chk("R7 data", hs_type, 1);
    ack(4'd3);
    chk("R3 other-ep ack", reg_rdata[7], 0);
    // R4 endpoint 2 ACK sets the shared flag
    ack(4'd2);
    chk("R4 ep2 ack", reg_rdata[7], 1);
    // R5 write 0 to bit 7 does nothing
    wr(8'h00);
    chk("R5 write0", reg_rdata[7], 1);
    wr(8'h80);
    chk("R5 clear", reg_rdata[7], 0);
    wr(8'h00);
    chk("R5 no set by write", reg_rdata[7], 0);

    // R9 set and clear in the same cycle
    tok(4'd2);
    reg_wr = 1'b1;
    reg_wdata = 8'h80;
    ack_vld = 1'b1;
    ack_ep = 4'd2;
    tick();
    reg_wr = 1'b0;
    ack_vld = 1'b0;
    chk("R9 set wins", reg_rdata[7], 1);

    // sweep: interrupt enable, flag, arm, endpoint
    for (int ie = 0; ie < 2; ie++) begin
      for (int f = 0; f < 2; f++) begin
        for (int arm = 0; arm < 2; arm++) begin
          for (int ep = 0; ep < 16; ep++) begin
            int shared_ep;
            int e_type;
            do_reset();
            if (f == 1) begin
              set_flag(4'(1 + (ep % 2)), 1'b0);
              wr({7'b0, 1'(ie)});
            end else begin
              wr({1'b1, 6'b0, 1'(ie)});
            end
            tx_arm = 1'(arm);
            // R8
            chk("R8 irq", irq, f & ie);
            tok(4'(ep));
            shared_ep = (ep == 1 || ep == 2) ? 1 : 0;
            e_type = shared_ep == 0 ? 0 : ((f == 0 && arm == 1) ? 1 : 2);
            if (shared_ep == 1) begin
              // R6 / R7
              chk("R6 hs_vld", hs_vld, 1);
              chk("R7 hs_type", hs_type, e_type);
            end else begin
              // R10
              chk("R10 hs_vld", hs_vld, 0);
              chk("R10 hs_type", hs_type, 0);
            end
            chk("R10 flag kept", reg_rdata, (f << 7) | ie);
            chk("R8 irq after", irq, f & ie);
          end
        end
      end
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule